// File: doc/BRIEF.md
# Rail Power-Good Monitor

This block decides whether one supply rail may be reported as good. A sampled output-voltage code and the rail's target code, both in millivolts, are compared every clock against two percentage thresholds of the target. The rising threshold is 96 % and the falling threshold is 93 %, so the flag has hysteresis. Because the target is an input and not a constant, both thresholds follow it when it changes. The rail's enable flag and a chip-wide force-low request from the fault supervisor can drop the flag at any time.

Whenever the flag goes low, for any reason, a hold timer of 50 millisecond ticks starts. The flag can rise again only after that timer has run out, the rail is enabled, the force-low request is clear and the measurement is at or above the rising threshold. When a fault is shorter than the hold, the flag returns when the hold ends. When a fault outlasts the hold, the flag returns on the first clock after the fault clears. The single output is an active-low pull-down enable for an open-drain line: 0 pulls the line down, and 1 releases it so the external pull-up can raise it.

Top module: `pg_hyst_mon`

## Requirements
- R1: While reset is asserted and after reset is released, `pg_pd_n` is 0, and the 50-tick hold is loaded as if the flag had just fallen.
- R2: With the hold expired, `rail_en`=1 and `force_low`=0, `pg_pd_n` becomes 1 on the clock edge at which meas_mv×100 ≥ target_mv×96. At target 1000, a measurement of 960 qualifies and 959 does not.
- R3: `pg_pd_n` becomes 0 on the clock edge at which meas_mv×100 < target_mv×93. At target 1000, a measurement of 929 drops the flag and 930 does not.
- R4: While the measurement lies between the two thresholds and no other cause applies, `pg_pd_n` keeps its previous value, whether that value is 0 or 1.
- R5: `rail_en`=0 drives `pg_pd_n` to 0 on the next clock edge.
- R6: `force_low`=1 drives `pg_pd_n` to 0 on the next clock edge and holds it at 0 for as long as the request stays high.
- R7: After every 1-to-0 transition of `pg_pd_n`, the output stays 0 until `ms_tick` has been sampled high on 50 later edges. The edge of the drop itself does not count.
- R8: After a force-low pulse shorter than the hold, `pg_pd_n` returns to 1 on the edge after the 50th tick, provided the measurement is at or above the rising threshold.
- R9: After a force-low request longer than the hold, `pg_pd_n` returns to 1 on the first edge at which the request is low, provided the measurement is at or above the rising threshold.
- R10: The thresholds follow the present `target_mv`. Raising the target above a steady measurement drops the flag, as in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| rail_en | input | 1 | Rail enabled |
| force_low | input | 1 | Supervisor request to drop the flag |
| meas_mv | input | MV_W | Measured output voltage, mV |
| target_mv | input | MV_W | Target output voltage, mV |
| pg_pd_n | output | 1 | Pull-down enable, active low (0 pulls, 1 releases) |

## Verification
Every input takes effect through one register, so any change driven between edges shows on `pg_pd_n` after the next rising edge. The bench drives its inputs on falling edges and compares with its reference model on the following falling edge. The hold release is due on the edge after the 50th sampled tick. The reference counts ticks at the same edges the design samples them, so a release that comes one tick early or late is reported. The threshold boundaries (929/930 and 959/960 at target 1000) and the target change are each checked one cycle after the input change.

// File: rtl/pg_hyst_mon.sv
module pg_hyst_mon #(
  parameter int MV_W     = 16,
  parameter int RISE_PCT = 96,
  parameter int FALL_PCT = 93,
  parameter int HOLD_MS  = 50
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ms_tick,
  input  logic            rail_en,
  input  logic            force_low,
  input  logic [MV_W-1:0] meas_mv,
  input  logic [MV_W-1:0] target_mv,
  output logic            pg_pd_n
);
  localparam int PW = MV_W + 7;
  localparam int HW = $clog2(HOLD_MS + 1);

  logic [PW-1:0] meas_scaled, rise_lvl, fall_lvl;
  logic          above, below, kill, drop, hold_done;
  logic [HW-1:0] hold_cnt;
  logic          good;

  assign meas_scaled = PW'(meas_mv) * PW'(100);
  assign rise_lvl    = PW'(target_mv) * PW'(RISE_PCT);
  assign fall_lvl    = PW'(target_mv) * PW'(FALL_PCT);
  assign above       = meas_scaled >= rise_lvl;
  assign below       = meas_scaled <  fall_lvl;
  assign kill        = !rail_en || force_low || below;
  assign drop        = good && kill;
  assign hold_done   = hold_cnt == '0;
  assign pg_pd_n     = good;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good     <= 1'b0;
      hold_cnt <= HW'(HOLD_MS);
    end else begin
      if (kill)
        good <= 1'b0;
      else if (above && hold_done)
        good <= 1'b1;

      if (drop)
        hold_cnt <= HW'(HOLD_MS);
      else if (ms_tick && !hold_done)
        hold_cnt <= hold_cnt - HW'(1);
    end
  end

  p_disable_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rail_en |=> !pg_pd_n);
  p_force_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    force_low |=> !pg_pd_n);
  p_fall_thresh_r3: assert property (@(posedge clk) disable iff (!rst_n)
    below |=> !pg_pd_n);
  p_rise_needs_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_pd_n) |-> $past(above));
  p_rise_after_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_pd_n) |-> $past(hold_cnt) == '0);
  p_hold_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_en && !force_low && !above && !below) |=> pg_pd_n == $past(pg_pd_n));
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_en && !force_low && above && hold_cnt == '0) |=> pg_pd_n);
  p_reset_low_r1: assert property (@(posedge clk)
    !rst_n |-> !pg_pd_n);
endmodule

// File: tb/pg_hyst_mon_tb.sv
module pg_hyst_mon_tb;
  localparam int HOLD = 50;
  localparam int TICK_DIV = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ms_tick = 1'b0;
  logic        rail_en = 1'b0;
  logic        force_low = 1'b0;
  logic [15:0] meas_mv = 16'd0;
  logic [15:0] target_mv = 16'd1800;
  logic        pg_pd_n;

  int    errors = 0;
  int    checks = 0;
  bit    finished = 0;
  string phase = "R1";

  int    m_good = 0;
  int    m_ticks_left = HOLD;
  int    tick_div_cnt = 0;

  always #2 clk = ~clk;

  pg_hyst_mon u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .rail_en(rail_en),
    .force_low(force_low), .meas_mv(meas_mv), .target_mv(target_mv),
    .pg_pd_n(pg_pd_n)
  );

  always @(negedge clk) begin
    tick_div_cnt = (tick_div_cnt == TICK_DIV - 1) ? 0 : tick_div_cnt + 1;
    ms_tick <= (tick_div_cnt == 0);
  end

  // reference: integer percentages, a count of remaining ticks
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_good = 0;
      m_ticks_left = HOLD;
    end else begin
      int  m100, hi, lo, old_left;
      bit  must_fall;
      m100 = int'(meas_mv) * 100;
      hi   = int'(target_mv) * 96;
      lo   = int'(target_mv) * 93;
      must_fall = !rail_en || force_low || (m100 < lo);
      old_left = m_ticks_left;
      if (must_fall && m_good == 1) m_ticks_left = HOLD;
      else if (ms_tick && old_left > 0) m_ticks_left = old_left - 1;
      if (must_fall) m_good = 0;
      else if (m100 >= hi && old_left == 0) m_good = 1;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (pg_pd_n !== 1'(m_good)) begin
        errors++;
        $display("FAIL model %s: pg_pd_n=%0b expected %0d at %0t", phase, pg_pd_n, m_good, $time);
      end
    end
  end

  task automatic expect_pg(input bit exp, input string req);
    checks++;
    if (pg_pd_n !== exp) begin
      errors++;
      $display("FAIL %s: pg_pd_n=%0b expected %0b at %0t", req, pg_pd_n, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    cycles(3);
    expect_pg(1'b0, "R1 in reset");
    rail_en = 1'b1; meas_mv = 16'd1800; target_mv = 16'd1800;
    rst_n = 1'b1;
    cycles(5);
    expect_pg(1'b0, "R1 hold after reset");
    phase = "R7";
    cycles(300);
    expect_pg(1'b0, "R7 still holding after reset");
    phase = "R2";
    cycles(300);
    expect_pg(1'b1, "R2 released after hold");

    phase = "R4";
    meas_mv = 16'd1700; cycles(1);
    expect_pg(1'b1, "R4 between keeps high");
    phase = "R3";
    meas_mv = 16'd1670; cycles(1);
    expect_pg(1'b0, "R3 below falling level");
    phase = "R7";
    meas_mv = 16'd1800; cycles(200);
    expect_pg(1'b0, "R7 minimum low time");
    cycles(400);
    expect_pg(1'b1, "R7 release after hold");

    // boundaries at target 1000
    phase = "R3";
    target_mv = 16'd1000; meas_mv = 16'd970; cycles(1);
    expect_pg(1'b1, "R10 retarget above rise");
    meas_mv = 16'd930; cycles(1);
    expect_pg(1'b1, "R3 930 is not below");
    meas_mv = 16'd929; cycles(1);
    expect_pg(1'b0, "R3 929 is below");
    phase = "R2";
    cycles(600);
    meas_mv = 16'd959; cycles(1);
    expect_pg(1'b0, "R4 959 between keeps low");
    meas_mv = 16'd960; cycles(1);
    expect_pg(1'b1, "R2 960 reaches rise");

    phase = "R8";
    force_low = 1'b1; cycles(1);
    expect_pg(1'b0, "R6 force pulls low");
    cycles(99);
    force_low = 1'b0; cycles(1);
    expect_pg(1'b0, "R8 short fault still held");
    cycles(600);
    expect_pg(1'b1, "R8 short fault released after hold");

    phase = "R9";
    force_low = 1'b1; cycles(800);
    expect_pg(1'b0, "R6 force held low");
    force_low = 1'b0; cycles(1);
    expect_pg(1'b1, "R9 long fault released at once");

    phase = "R5";
    rail_en = 1'b0; cycles(1);
    expect_pg(1'b0, "R5 disable pulls low");
    cycles(700);
    expect_pg(1'b0, "R5 stays low while disabled");
    rail_en = 1'b1; cycles(1);
    expect_pg(1'b1, "R5 re-enable after hold");

    phase = "R10";
    target_mv = 16'd1800; meas_mv = 16'd1800; cycles(2);
    expect_pg(1'b1, "R10 steady at 1800");
    target_mv = 16'd2650; cycles(1);
    expect_pg(1'b0, "R10 raised target drops flag");
    cycles(600);
    meas_mv = 16'd2650; cycles(1);
    expect_pg(1'b1, "R10 meets new target");

    cycles(5);
    finish_run();
  end

  initial begin
    cycles(150000);
    errors++;
    $display("FAIL watchdog: run did not end, expected finish");
    finish_run();
  end
endmodule